// File: doc/BRIEF.md
# Message Object Interface Transfer Unit

This block sits between a CPU-facing set of interface registers and a small message-object store inside a CAN-style controller. The interface registers are a 3-bit control/status register (pending-interrupt, new-data and transmit-request flags) and two 16-bit data registers that together hold payload bytes 0 to 3. Software loads these registers and then issues a command. The command carries a direction bit, an object number and a 4-bit mask that selects which field groups move.

In write direction, the selected register groups are copied into the named object. In read direction, the selected object fields are copied into the registers. A read can also clear the object's pending-interrupt and new-data flags as part of the same transfer, and the register always receives the flag values from before the clear. The meaning of the shared transmit/new-data access bit depends on the direction. Each transfer keeps a busy flag high for a fixed number of cycles. Commands that arrive while busy is high are dropped.

Top module: `msgobj_xfer`

## Requirements
- R1: `cmdWrNrd`=1 moves data from the interface registers into the object, and `cmdWrNrd`=0 moves data from the object into the interface registers.
- R2: A command accepted at a clock edge (`cmdWr`=1 while `busy`=0) raises `busy` for exactly 3 cycles. The transfer's effects appear on the outputs and in the object at the edge where `busy` falls.
- R3: A `cmdWr` pulse while `busy`=1 is ignored and touches no object.
- R4: With mask bit 3 (control) set, a write copies `ctlIn`-loaded register flags into the object and a read copies the object's flags into the control register. With it clear, the object's flags and the control register are untouched by the control group. Flag positions are bit 2 pending-interrupt, bit 1 new-data and bit 0 transmit-request.
- R5: With mask bit 2 (clear-pending) set, a read clears the object's pending-interrupt flag. On a write this bit has no effect.
- R6: On a write with mask bit 1 set, the object's transmit-request flag becomes 1 whatever the register's transmit-request bit holds.
- R7: On a read with mask bit 1 set, the object's new-data flag is cleared.
- R8: When a read clears flags, the control register receives the object's flag values from before the clear.
- R9: With mask bit 0 (data) set, bytes 0 to 3 move: byte 0 in `data1` bits 7:0, byte 1 in `data1` bits 15:8, byte 2 in `data2` bits 7:0 and byte 3 in `data2` bits 15:8. With it clear, the data bytes on both sides are unchanged.
- R10: Object numbers 0 and any value above 32 are invalid. Such a command still holds busy for 3 cycles but changes no object and no register.
- R11: After reset, `busy`, all interface registers and all object fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command strobe |
| cmdWrNrd | input | 1 | Direction: 1 = registers to object, 0 = object to registers |
| cmdObj | input | 6 | Object number, valid range 1 to 32 |
| cmdMask | input | 4 | Access mask: [3] control, [2] clear-pending, [1] transmit/new-data, [0] data |
| ctlWr | input | 1 | Load the control register from ctlIn |
| ctlIn | input | 3 | Control value: [2] pending-interrupt, [1] new-data, [0] transmit-request |
| data1Wr | input | 1 | Load data register 1 |
| data1In | input | 16 | Bytes 1:0 for data register 1 |
| data2Wr | input | 1 | Load data register 2 |
| data2In | input | 16 | Bytes 3:2 for data register 2 |
| busy | output | 1 | Transfer in progress |
| ctlOut | output | 3 | Control register contents |
| data1Out | output | 16 | Data register 1 contents |
| data2Out | output | 16 | Data register 2 contents |

## Verification
The assertions check on every cycle that an accepted command raises busy, that busy stays high for exactly three cycles, and that the interface registers change only on a CPU load or at the edge where busy falls. The bench's scenarios are the only proof of what each mask bit means in each direction. They cover the pre-clear flag values returned by a read, the forced transmit request, dropped commands and invalid object numbers. These are visible only after a later read-back through the same registers.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
  typedef struct packed {
    logic control;
    logic clrIntPnd;
    logic txNewDat;
    logic dataA;
  } accMask_t;

  typedef struct packed {
    logic intPnd;
    logic newDat;
    logic txRqst;
  } objCtl_t;

  typedef struct packed {
    logic     fire;
    logic     valid;
    logic     wrNrd;
    accMask_t mask;
  } xferStb_t;
endpackage

// File: rtl/msgobj_ctrl.sv
module msgobj_ctrl
  import msgobj_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int BUSY_CYC = 3,
  parameter int OBJ_W    = 6,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic             cmdWrNrd,
  input  logic [OBJ_W-1:0] cmdObj,
  input  logic [3:0]       cmdMask,
  output logic             busy,
  output xferStb_t         stb,
  output logic [IDX_W-1:0] idx
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [OBJ_W-1:0] objQ;
  logic             wrNrdQ;
  accMask_t         maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      objQ   <= '0;
      wrNrdQ <= 1'b0;
      maskQ  <= '0;
    end else if (!busy) begin
      if (cmdWr) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(BUSY_CYC - 1);
        objQ   <= cmdObj;
        wrNrdQ <= cmdWrNrd;
        maskQ  <= accMask_t'(cmdMask);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    stb.fire  = busy && (cnt == '0);
    stb.valid = (objQ != '0) && (objQ <= OBJ_W'(NUM_OBJ));
    stb.wrNrd = wrNrdQ;
    stb.mask  = maskQ;
    idx       = IDX_W'(objQ - OBJ_W'(1));
  end
endmodule

// File: rtl/msgobj_dpath.sv
module msgobj_dpath
  import msgobj_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStb_t          stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ctlWr,
  input  logic [2:0]        ctlIn,
  input  logic              data1Wr,
  input  logic [DATA_W-1:0] data1In,
  input  logic              data2Wr,
  input  logic [DATA_W-1:0] data2In,
  output logic [2:0]        ctlOut,
  output logic [DATA_W-1:0] data1Out,
  output logic [DATA_W-1:0] data2Out
);
  localparam int PAY_W = 2 * DATA_W;

  objCtl_t           objFlag [NUM_OBJ];
  logic [PAY_W-1:0]  objData [NUM_OBJ];
  objCtl_t           ctlQ;
  logic [DATA_W-1:0] d1Q, d2Q;
  logic              doWr, doRd;

  assign doWr = stb.fire && stb.valid && stb.wrNrd;
  assign doRd = stb.fire && stb.valid && !stb.wrNrd;

  // object store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OBJ; i++) begin
        objFlag[i] <= '0;
        objData[i] <= '0;
      end
    end else if (doWr) begin
      if (stb.mask.control) begin
        objFlag[idx].intPnd <= ctlQ.intPnd;
        objFlag[idx].newDat <= ctlQ.newDat;
        objFlag[idx].txRqst <= ctlQ.txRqst | stb.mask.txNewDat;
      end else if (stb.mask.txNewDat) begin
        objFlag[idx].txRqst <= 1'b1;
      end
      if (stb.mask.dataA) objData[idx] <= {d2Q, d1Q};
    end else if (doRd) begin
      if (stb.mask.clrIntPnd) objFlag[idx].intPnd <= 1'b0;
      if (stb.mask.txNewDat)  objFlag[idx].newDat <= 1'b0;
    end
  end

  // interface registers; a read transfer wins over a CPU load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      d1Q  <= '0;
      d2Q  <= '0;
    end else begin
      if (doRd && stb.mask.control) ctlQ <= objFlag[idx];
      else if (ctlWr)               ctlQ <= objCtl_t'(ctlIn);
      if (doRd && stb.mask.dataA) begin
        d1Q <= objData[idx][DATA_W-1:0];
        d2Q <= objData[idx][PAY_W-1:DATA_W];
      end else begin
        if (data1Wr) d1Q <= data1In;
        if (data2Wr) d2Q <= data2In;
      end
    end
  end

  assign ctlOut   = ctlQ;
  assign data1Out = d1Q;
  assign data2Out = d2Q;
endmodule

// File: rtl/msgobj_xfer.sv
module msgobj_xfer
  import msgobj_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int BUSY_CYC = 3,
  parameter int DATA_W   = 16,
  parameter int OBJ_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              cmdWrNrd,
  input  logic [OBJ_W-1:0]  cmdObj,
  input  logic [3:0]        cmdMask,
  input  logic              ctlWr,
  input  logic [2:0]        ctlIn,
  input  logic              data1Wr,
  input  logic [DATA_W-1:0] data1In,
  input  logic              data2Wr,
  input  logic [DATA_W-1:0] data2In,
  output logic              busy,
  output logic [2:0]        ctlOut,
  output logic [DATA_W-1:0] data1Out,
  output logic [DATA_W-1:0] data2Out
);
  localparam int IDX_W = $clog2(NUM_OBJ);

  xferStb_t         stb;
  logic [IDX_W-1:0] idx;

  msgobj_ctrl #(.NUM_OBJ(NUM_OBJ), .BUSY_CYC(BUSY_CYC), .OBJ_W(OBJ_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWrNrd(cmdWrNrd),
    .cmdObj(cmdObj), .cmdMask(cmdMask), .busy(busy), .stb(stb), .idx(idx)
  );

  msgobj_dpath #(.NUM_OBJ(NUM_OBJ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx),
    .ctlWr(ctlWr), .ctlIn(ctlIn), .data1Wr(data1Wr), .data1In(data1In),
    .data2Wr(data2Wr), .data2In(data2In),
    .ctlOut(ctlOut), .data1Out(data1Out), .data2Out(data2Out)
  );
endmodule

// File: rtl/msgobj_xfer_chk.sv
module msgobj_xfer_chk #(
  parameter int BUSY_CYC = 3,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWr,
  input logic              busy,
  input logic              ctlWr,
  input logic              data1Wr,
  input logic              data2Wr,
  input logic [2:0]        ctlOut,
  input logic [DATA_W-1:0] data1Out,
  input logic [DATA_W-1:0] data2Out
);
  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  // R2
  accept_raises_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !busy |=> busy);

  // R2
  busy_run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < 8'(BUSY_CYC));

  // R2
  busy_run_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == 8'(BUSY_CYC));

  // R3
  data1_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!data1Wr) && !$fell(busy) |-> $stable(data1Out));

  // R3
  data2_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!data2Wr) && !$fell(busy) |-> $stable(data2Out));

  // R4
  ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctlWr) && !$fell(busy) |-> $stable(ctlOut));
endmodule

bind msgobj_xfer msgobj_xfer_chk #(.BUSY_CYC(BUSY_CYC), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/msgobj_xfer_tb.sv
module msgobj_xfer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0, cmdWrNrd = 1'b0;
  logic [5:0]  cmdObj = '0;
  logic [3:0]  cmdMask = '0;
  logic        ctlWr = 1'b0, data1Wr = 1'b0, data2Wr = 1'b0;
  logic [2:0]  ctlIn = '0;
  logic [15:0] data1In = '0, data2In = '0;
  logic        busy;
  logic [2:0]  ctlOut;
  logic [15:0] data1Out, data2Out;

  int    errors = 0, checks = 0;
  string tag = "R11";

  // reference model state
  int          mBusy = 0;
  bit          lWr;
  int          lObj;
  logic [3:0]  lMask;
  logic [2:0]  mFlag [64];
  logic [31:0] mData [64];
  logic [2:0]  mCtl = '0;
  logic [15:0] mD1 = '0, mD2 = '0;

  msgobj_xfer u_dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWrNrd(cmdWrNrd), .cmdObj(cmdObj),
    .cmdMask(cmdMask), .ctlWr(ctlWr), .ctlIn(ctlIn), .data1Wr(data1Wr),
    .data1In(data1In), .data2Wr(data2Wr), .data2In(data2In),
    .busy(busy), .ctlOut(ctlOut), .data1Out(data1Out), .data2Out(data2Out)
  );

  always #5 clk = ~clk;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: advance the model, then compare away from the edge
  task automatic step();
    bit          done = 0;
    logic [2:0]  oCtl = mCtl;
    logic [15:0] o1 = mD1, o2 = mD2;
    if (mBusy > 0) begin
      mBusy--;
      if (mBusy == 0) done = 1;
    end else if (cmdWr) begin
      mBusy = 3; lWr = cmdWrNrd; lObj = int'(cmdObj); lMask = cmdMask;
    end
    if (ctlWr) mCtl = ctlIn;
    if (data1Wr) mD1 = data1In;
    if (data2Wr) mD2 = data2In;
    if (done && lObj >= 1 && lObj <= 32) begin
      if (lWr) begin
        if (lMask[3]) mFlag[lObj] = oCtl;
        if (lMask[1]) mFlag[lObj][0] = 1'b1;
        if (lMask[0]) mData[lObj] = {o2, o1};
      end else begin
        if (lMask[3]) mCtl = mFlag[lObj];
        if (lMask[0]) begin mD1 = mData[lObj][15:0]; mD2 = mData[lObj][31:16]; end
        if (lMask[2]) mFlag[lObj][2] = 1'b0;
        if (lMask[1]) mFlag[lObj][1] = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    check("busy", 32'(busy), 32'(mBusy > 0));
    check("ctlOut", 32'(ctlOut), 32'(mCtl));
    check("data1Out", 32'(data1Out), 32'(mD1));
    check("data2Out", 32'(data2Out), 32'(mD2));
  endtask

  task automatic setRegs(logic [2:0] c, logic [15:0] a, logic [15:0] b);
    ctlWr = 1; data1Wr = 1; data2Wr = 1; ctlIn = c; data1In = a; data2In = b;
    step();
    ctlWr = 0; data1Wr = 0; data2Wr = 0;
  endtask

  task automatic cmd(bit wr, int obj, logic [3:0] mask);
    cmdWr = 1; cmdWrNrd = wr; cmdObj = 6'(obj); cmdMask = mask;
    step();
    cmdWr = 0;
    for (int k = 0; k < 3; k++) step();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mFlag[i] = '0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    rstN = 1;
    // R11: reset state, and an object read returns zeros
    tag = "R11"; step();
    cmd(0, 7, 4'b1001);

    // R1 R9: data round trip through object 5
    tag = "R1";  setRegs(3'b000, 16'hA1B2, 16'hC3D4); cmd(1, 5, 4'b0001);
    tag = "R9";  setRegs(3'b000, 16'h0000, 16'h0000); cmd(0, 5, 4'b0001);

    // R4 R6: control write with forced transmit request
    tag = "R6";  setRegs(3'b110, 16'h0, 16'h0); cmd(1, 9, 4'b1010);
    tag = "R4";  setRegs(3'b000, 16'h0, 16'h0); cmd(0, 9, 4'b1000);

    // R8 R5 R7: read-and-clear returns pre-clear flags, then re-read
    tag = "R8";  cmd(0, 9, 4'b1110);
    tag = "R7";  setRegs(3'b000, 16'h0, 16'h0); cmd(0, 9, 4'b1000);

    // R5: clear-pending ignored on a write
    tag = "R5";  setRegs(3'b100, 16'h0, 16'h0); cmd(1, 9, 4'b1100);
    setRegs(3'b000, 16'h0, 16'h0); cmd(0, 9, 4'b1000);

    // R4: control clear leaves the control register alone on a read
    tag = "R4";  setRegs(3'b011, 16'h0, 16'h0); cmd(0, 9, 4'b0001);

    // R9: data bit clear leaves object data unchanged on a write
    tag = "R9";  setRegs(3'b000, 16'h1234, 16'h5678); cmd(1, 5, 4'b1000);
    cmd(0, 5, 4'b0001);

    // R10: invalid object numbers
    tag = "R10"; setRegs(3'b111, 16'h1111, 16'h2222); cmd(1, 0, 4'b1011);
    cmd(1, 40, 4'b1011); cmd(0, 0, 4'b1111); cmd(0, 33, 4'b1111);
    cmd(0, 32, 4'b1001);

    // R3: a command during busy is dropped
    tag = "R3";  setRegs(3'b000, 16'hBEEF, 16'hCAFE);
    cmdWr = 1; cmdWrNrd = 1; cmdObj = 12; cmdMask = 4'b0001; step();
    cmdObj = 13; step(); cmdWr = 0; step(); step();
    setRegs(3'b000, 16'h0, 16'h0); cmd(0, 13, 4'b0001);
    cmd(0, 12, 4'b0001);

    // R2: back-to-back commands
    tag = "R2";  cmd(1, 20, 4'b0011); cmd(0, 20, 4'b1011);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule